// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts down in coarse ticks and escalates in two steps. A parameterised prescaler divides the system clock into ticks. Each time the count runs out, a timeout flag is set. The block can also raise a system-management interrupt (SMI) request, and it then reloads the count and keeps going. If the count runs out a second time in a row with no software reload in between, the block records a boot failure. It then asks for a reboot and halts, unless one of two suppress inputs is active.

Software reaches the block through a small byte-addressed register window. The window holds:
- the reload/count register
- a limit register that sets the period in ticks
- data-in and data-out mailboxes
- two status registers and two control registers
- two message bytes, a watchdog count byte and a software interrupt byte

Each access moves one byte or a little-endian 16-bit word at any byte offset. The register port is a plain, always-ready write strobe. Read data is combinational from the offset, so there is no back-pressure anywhere on the block.

Top module: `wdt_top`

Register offsets (byte): reload 0x00, limit 0x02, data-in 0x04, data-out 0x05, status-1 0x06, status-2 0x08, control-1 0x0A, control-2 0x0C, message-A 0x0E, message-B 0x0F, watchdog count 0x10, software interrupt 0x11. The count field is bits [CNT_W-1:0] of reload and limit.

Register bits:
- status-1: bit 1 software-SMI, bit 2 interrupt, bit 3 timeout.
- status-2: bit 1 second-timeout, bit 2 boot-failure.
- control-1: bit 11 halt, bit 12 lock.

## Requirements
- R1: After reset, limit reads 0x0004, control-2 reads 0x0008, the software interrupt byte reads 0x03, every other register reads 0, and smi_o, reboot_o and irq_o are low.
- R2: A write to control-1 starts the countdown from the limit value only when halt (bit 11) ends up clear and the full 16-bit limit is greater than 1; in every other case that write stops the countdown and leaves the count unchanged.
- R3: When the count runs out, status-1 bit 3 is set; no expiry occurs earlier than limit-1 full tick periods after a restart. If smi_en_i is high, smi_o gives one pulse and the count restarts from the limit.
- R4: On the second consecutive expiry, status-2 bits 1 and 2 are set. With both suppress inputs low, reboot_o gives one pulse, no SMI is raised, and the count is left at 0 and stopped.
- R5: With strap_no_reboot_i or cfg_no_reboot_i high, a second consecutive expiry still sets the status-2 bits, produces no reboot pulse, raises SMI when enabled, and keeps counting.
- R6: Any write to the reload register clears the consecutive-expiry record and restarts the count when running is allowed. When running is not allowed, the written value is stored as the reload contents.
- R7: Control-1 bit 12 (lock) can be set by a write, but only reset clears it.
- R8: A write to data-in stores the byte, sets status-1 bit 1 and pulses smi_o. A write to data-out stores the byte, sets status-1 bit 2, and raises irq_o.
- R9: While counting, the reload register reads the remaining ticks in its count field and the stored upper bits above it.
- R10: Writes to status-1 keep only bits 1-3 and writes to status-2 keep only bits 1-2. Byte writes change one byte. Word writes place data[7:0] at the offset and data[15:8] at offset+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_addr_i | input | 5 | Byte offset of the access |
| bus_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata_i | input | 16 | Write data, little-endian |
| bus_rdata_o | output | 16 | Read data for the current offset (upper byte 0 on byte access) |
| smi_en_i | input | 1 | Allows expiry to raise SMI |
| strap_no_reboot_i | input | 1 | Board strap that suppresses reboot |
| cfg_no_reboot_i | input | 1 | Configuration bit that suppresses reboot |
| smi_o | output | 1 | SMI request pulse |
| reboot_o | output | 1 | Reboot request pulse |
| irq_o | output | 1 | Interrupt flag (status-1 bit 2) |

## Verification
The assertions expect smi_en_i and the two suppress inputs to be stable on the edge where an expiry is taken. They also expect one register access at most per cycle, so that the reload and control-1 side effects never collide. The stimulus changes these inputs only while the timer is halted, and only on falling clock edges. Expiry checks are placed at points where tick-phase uncertainty cannot move the outcome. The bench waits at least one full tick period past the latest possible expiry and stays clear of the earliest possible next one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned NUM_BYTES = 18;

  localparam int unsigned OFS_RELOAD = 0;
  localparam int unsigned OFS_LIMIT  = 2;
  localparam int unsigned OFS_DIN    = 4;
  localparam int unsigned OFS_DOUT   = 5;
  localparam int unsigned OFS_STAT1  = 6;
  localparam int unsigned OFS_STAT2  = 8;
  localparam int unsigned OFS_CTRL1  = 10;
  localparam int unsigned OFS_CTRL2  = 12;
  localparam int unsigned OFS_MSGA   = 14;
  localparam int unsigned OFS_MSGB   = 15;
  localparam int unsigned OFS_WDCNT  = 16;
  localparam int unsigned OFS_SWIRQ  = 17;

  localparam int unsigned S1_SWSMI  = 1;
  localparam int unsigned S1_INT    = 2;
  localparam int unsigned S1_TOUT   = 3;
  localparam logic [15:0] S1_MASK   = 16'h000E;
  localparam int unsigned S2_SECOND = 1;
  localparam int unsigned S2_BOOT   = 2;
  localparam logic [15:0] S2_MASK   = 16'h0006;
  localparam int unsigned C1_HALT   = 11;
  localparam int unsigned C1_LOCK   = 12;
  localparam logic [15:0] C1_MASK   = 16'h1800;

  localparam logic [15:0] LIMIT_RST = 16'h0004;
  localparam logic [15:0] CTRL2_RST = 16'h0008;
  localparam logic [7:0]  SWIRQ_RST = 8'h03;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [15:0] limit_i,
  input  logic        restart_i,
  input  logic        stop_i,
  input  logic        store_i,
  input  logic [15:0] store_val_i,
  input  logic        clr_strike_i,
  input  logic        smi_en_i,
  input  logic        no_reboot_i,
  output logic [15:0] reload_o,
  output logic        tout_o,
  output logic        second_o,
  output logic        smi_o,
  output logic        reboot_o
);
  logic [15:0] rld_q;
  logic        run_q, strike_q;
  logic        tout_q, second_q, smi_q, reboot_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rld_q <= '0; run_q <= 1'b0; strike_q <= 1'b0;
      tout_q <= 1'b0; second_q <= 1'b0; smi_q <= 1'b0; reboot_q <= 1'b0;
    end else begin
      tout_q <= 1'b0; second_q <= 1'b0; smi_q <= 1'b0; reboot_q <= 1'b0;
      if (clr_strike_i) strike_q <= 1'b0;
      if (restart_i) begin
        rld_q <= limit_i;
        run_q <= 1'b1;
      end else if (stop_i) begin
        run_q <= 1'b0;
      end else if (store_i) begin
        rld_q <= store_val_i;
      end else if (run_q && tick_i) begin
        if (rld_q[CNT_W-1:0] > CNT_W'(1)) begin
          rld_q[CNT_W-1:0] <= rld_q[CNT_W-1:0] - CNT_W'(1);
        end else begin
          tout_q <= 1'b1;
          if (strike_q) begin
            second_q <= 1'b1;
            strike_q <= 1'b0;
            if (!no_reboot_i) begin
              reboot_q <= 1'b1;
              run_q    <= 1'b0;
              rld_q    <= '0;
            end else begin
              smi_q <= smi_en_i;
              rld_q <= limit_i;
            end
          end else begin
            strike_q <= 1'b1;
            smi_q    <= smi_en_i;
            rld_q    <= limit_i;
          end
        end
      end
    end
  end

  assign reload_o = rld_q;
  assign tout_o   = tout_q;
  assign second_o = second_q;
  assign smi_o    = smi_q;
  assign reboot_o = reboot_q;

  AST_START_NEEDS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ($past(limit_i) > 16'd1)); // R2
  AST_SMI_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_q |-> $past(smi_en_i)); // R3
  AST_REBOOT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_q |-> (!run_q && rld_q == 16'd0)); // R4
  AST_REBOOT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_q |-> !$past(no_reboot_i)); // R5
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [15:0]       reload_i,
  input  logic              tout_i,
  input  logic              second_i,
  output logic [15:0]       limit_o,
  output logic              restart_o,
  output logic              stop_o,
  output logic              store_o,
  output logic [15:0]       store_val_o,
  output logic              clr_strike_o,
  output logic              smi_o,
  output logic              irq_o
);
  logic [NUM_BYTES-1:0] be;
  logic [7:0]           bd [NUM_BYTES];
  logic [7:0]           rb [NUM_BYTES];

  logic [15:0] limit_q, s1_q, s2_q, c1_q, c2_q;
  logic [7:0]  din_q, dout_q, msga_q, msgb_q, wdcnt_q, swirq_q;
  logic        smi_q;

  function automatic logic [15:0] mrg(input logic [15:0] old, input logic el, input logic eh,
                                      input logic [7:0] dl, input logic [7:0] dh);
    return {eh ? dh : old[15:8], el ? dl : old[7:0]};
  endfunction

  always_comb begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      be[b] = wr_i && (addr_i == ADDR_W'(b));
      bd[b] = wdata_i[7:0];
      if (wr_i && word_i && ({1'b0, addr_i} + (ADDR_W+1)'(1) == (ADDR_W+1)'(b))) begin
        be[b] = 1'b1;
        bd[b] = wdata_i[15:8];
      end
    end
  end

  logic hit_rld, hit_lim, hit_s1, hit_s2, hit_c1, hit_c2;
  logic [15:0] c1_new;
  logic can_cur, can_new;

  always_comb begin
    hit_rld = be[OFS_RELOAD] | be[OFS_RELOAD+1];
    hit_lim = be[OFS_LIMIT]  | be[OFS_LIMIT+1];
    hit_s1  = be[OFS_STAT1]  | be[OFS_STAT1+1];
    hit_s2  = be[OFS_STAT2]  | be[OFS_STAT2+1];
    hit_c1  = be[OFS_CTRL1]  | be[OFS_CTRL1+1];
    hit_c2  = be[OFS_CTRL2]  | be[OFS_CTRL2+1];
    c1_new  = (mrg(c1_q, be[OFS_CTRL1], be[OFS_CTRL1+1], bd[OFS_CTRL1], bd[OFS_CTRL1+1]) & C1_MASK)
            | (c1_q & (16'd1 << C1_LOCK));
    can_cur = !c1_q[C1_HALT]   && (limit_q > 16'd1);
    can_new = !c1_new[C1_HALT] && (limit_q > 16'd1);
    restart_o    = (hit_rld && can_cur) || (hit_c1 && can_new);
    stop_o       = hit_c1 && !can_new;
    store_o      = hit_rld && !can_cur;
    clr_strike_o = hit_rld;
    store_val_o  = mrg(reload_i, be[OFS_RELOAD], be[OFS_RELOAD+1], bd[OFS_RELOAD], bd[OFS_RELOAD+1]);
  end

  logic [15:0] s1_n, s2_n;
  always_comb begin
    s1_n = hit_s1 ? (mrg(s1_q, be[OFS_STAT1], be[OFS_STAT1+1], bd[OFS_STAT1], bd[OFS_STAT1+1]) & S1_MASK) : s1_q;
    if (be[OFS_DIN])  s1_n[S1_SWSMI] = 1'b1;
    if (be[OFS_DOUT]) s1_n[S1_INT]   = 1'b1;
    if (tout_i)       s1_n[S1_TOUT]  = 1'b1;
    s2_n = hit_s2 ? (mrg(s2_q, be[OFS_STAT2], be[OFS_STAT2+1], bd[OFS_STAT2], bd[OFS_STAT2+1]) & S2_MASK) : s2_q;
    if (second_i) begin
      s2_n[S2_SECOND] = 1'b1;
      s2_n[S2_BOOT]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      limit_q <= LIMIT_RST; s1_q <= '0; s2_q <= '0; c1_q <= '0; c2_q <= CTRL2_RST;
      din_q <= '0; dout_q <= '0; msga_q <= '0; msgb_q <= '0; wdcnt_q <= '0;
      swirq_q <= SWIRQ_RST; smi_q <= 1'b0;
    end else begin
      if (hit_lim) limit_q <= mrg(limit_q, be[OFS_LIMIT], be[OFS_LIMIT+1], bd[OFS_LIMIT], bd[OFS_LIMIT+1]);
      if (hit_c1)  c1_q <= c1_new;
      if (hit_c2)  c2_q <= mrg(c2_q, be[OFS_CTRL2], be[OFS_CTRL2+1], bd[OFS_CTRL2], bd[OFS_CTRL2+1]);
      s1_q <= s1_n;
      s2_q <= s2_n;
      if (be[OFS_DIN])   din_q   <= bd[OFS_DIN];
      if (be[OFS_DOUT])  dout_q  <= bd[OFS_DOUT];
      if (be[OFS_MSGA])  msga_q  <= bd[OFS_MSGA];
      if (be[OFS_MSGB])  msgb_q  <= bd[OFS_MSGB];
      if (be[OFS_WDCNT]) wdcnt_q <= bd[OFS_WDCNT];
      if (be[OFS_SWIRQ]) swirq_q <= bd[OFS_SWIRQ];
      smi_q <= be[OFS_DIN];
    end
  end

  always_comb begin
    rb[OFS_RELOAD] = reload_i[7:0]; rb[OFS_RELOAD+1] = reload_i[15:8];
    rb[OFS_LIMIT]  = limit_q[7:0];  rb[OFS_LIMIT+1]  = limit_q[15:8];
    rb[OFS_DIN]    = din_q;         rb[OFS_DOUT]     = dout_q;
    rb[OFS_STAT1]  = s1_q[7:0];     rb[OFS_STAT1+1]  = s1_q[15:8];
    rb[OFS_STAT2]  = s2_q[7:0];     rb[OFS_STAT2+1]  = s2_q[15:8];
    rb[OFS_CTRL1]  = c1_q[7:0];     rb[OFS_CTRL1+1]  = c1_q[15:8];
    rb[OFS_CTRL2]  = c2_q[7:0];     rb[OFS_CTRL2+1]  = c2_q[15:8];
    rb[OFS_MSGA]   = msga_q;        rb[OFS_MSGB]     = msgb_q;
    rb[OFS_WDCNT]  = wdcnt_q;       rb[OFS_SWIRQ]    = swirq_q;
  end

  logic [7:0] rd_lo, rd_hi;
  always_comb begin
    rd_lo = 8'h00;
    rd_hi = 8'h00;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == ADDR_W'(b)) rd_lo = rb[b];
      if ({1'b0, addr_i} + (ADDR_W+1)'(1) == (ADDR_W+1)'(b)) rd_hi = rb[b];
    end
    rdata_o = {word_i ? rd_hi : 8'h00, rd_lo};
  end

  assign limit_o = limit_q;
  assign smi_o   = smi_q;
  assign irq_o   = s1_q[S1_INT];

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1_q[C1_LOCK] |=> c1_q[C1_LOCK]); // R7
  AST_DIN_SETS_SWSMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_q |-> s1_q[S1_SWSMI]); // R8
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE = 1000,
  parameter int unsigned CNT_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_word_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  input  logic              smi_en_i,
  input  logic              strap_no_reboot_i,
  input  logic              cfg_no_reboot_i,
  output logic              smi_o,
  output logic              reboot_o,
  output logic              irq_o
);
  logic        tick, tout, second, cd_smi, rg_smi;
  logic        restart, stop, store, clr_strike;
  logic [15:0] limit, reload, store_val;

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  wdt_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .word_i(bus_word_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .reload_i(reload), .tout_i(tout), .second_i(second), .limit_o(limit),
    .restart_o(restart), .stop_o(stop), .store_o(store), .store_val_o(store_val),
    .clr_strike_o(clr_strike), .smi_o(rg_smi), .irq_o(irq_o)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .limit_i(limit),
    .restart_i(restart), .stop_i(stop), .store_i(store), .store_val_i(store_val),
    .clr_strike_i(clr_strike), .smi_en_i(smi_en_i),
    .no_reboot_i(strap_no_reboot_i | cfg_no_reboot_i),
    .reload_o(reload), .tout_o(tout), .second_o(second), .smi_o(cd_smi),
    .reboot_o(reboot_o)
  );

  assign smi_o = cd_smi | rg_smi;
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int P = 4;
  localparam logic [4:0] A_RLD = 5'h00, A_LIM = 5'h02, A_DIN = 5'h04, A_DOUT = 5'h05,
                         A_S1 = 5'h06, A_S2 = 5'h08, A_C1 = 5'h0A, A_C2 = 5'h0C,
                         A_MSGA = 5'h0E, A_WDC = 5'h10, A_SWI = 5'h11;
  localparam logic [15:0] HALT = 16'h0800, LOCK = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, word = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic smi_en = 1'b0, strap = 1'b0, cfg = 1'b0;
  logic smi, reboot, irq;
  int n_chk = 0, n_err = 0, smi_cnt = 0, rb_cnt = 0;

  always #5 clk = ~clk;

  wdt_top #(.PRESCALE(P), .CNT_W(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .smi_en_i(smi_en), .strap_no_reboot_i(strap), .cfg_no_reboot_i(cfg),
    .smi_o(smi), .reboot_o(reboot), .irq_o(irq)
  );

  always @(posedge clk) if (rst_n) begin
    if (smi) smi_cnt++;
    if (reboot) rb_cnt++;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; word = w; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic w, output logic [15:0] q);
    addr = a; word = w;
    #1 q = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset;
    logic [15:0] v;
    rd_reg(A_RLD, 1, v);  check("R1 reload", v, 16'h0000);
    rd_reg(A_LIM, 1, v);  check("R1 limit", v, 16'h0004);
    rd_reg(A_DIN, 1, v);  check("R1 din/dout", v, 16'h0000);
    rd_reg(A_S1, 1, v);   check("R1 status1", v, 16'h0000);
    rd_reg(A_S2, 1, v);   check("R1 status2", v, 16'h0000);
    rd_reg(A_C1, 1, v);   check("R1 ctrl1", v, 16'h0000);
    rd_reg(A_C2, 1, v);   check("R1 ctrl2", v, 16'h0008);
    rd_reg(A_MSGA, 1, v); check("R1 msgs", v, 16'h0000);
    rd_reg(A_WDC, 0, v);  check("R1 wdcnt", v, 16'h0000);
    rd_reg(A_SWI, 0, v);  check("R1 swirq", v, 16'h0003);
    check("R1 outputs", {13'd0, smi, reboot, irq}, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, v1, v2;
    int s0, r0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    check_reset();

    // R2 / R6 / R9: sweep limit values and halt
    for (int t = 0; t < 8; t++) begin
      for (int h = 0; h < 2; h++) begin
        bit runs;
        runs = (h == 0) && (t > 1);
        wr_reg(A_C1, 1, HALT);
        wr_reg(A_RLD, 1, 16'h0155);
        wr_reg(A_LIM, 1, 16'(t));
        wr_reg(A_C1, 1, h ? HALT : 16'h0000);
        rd_reg(A_RLD, 1, v);
        check($sformatf("R2 start t=%0d h=%0d", t, h), v, runs ? 16'(t) : 16'h0155);
        wait_cyc(P);
        rd_reg(A_RLD, 1, v);
        check($sformatf("R9 count t=%0d h=%0d", t, h), v, runs ? 16'(t - 1) : 16'h0155);
      end
    end

    // R9: upper bits read back while counting
    wr_reg(A_C1, 1, HALT);
    wr_reg(A_LIM, 1, 16'h8403);
    wr_reg(A_C1, 1, 16'h0000);
    rd_reg(A_RLD, 1, v); check("R9 upper start", v, 16'h8403);
    wait_cyc(P);
    rd_reg(A_RLD, 1, v); check("R9 upper tick", v, 16'h8402);

    // R3 / R4 / R5: sweep smi enable and both suppress inputs
    for (int s = 0; s < 8; s++) begin
      bit do_rb;
      wr_reg(A_C1, 1, HALT);
      wr_reg(A_S1, 1, 16'h0000);
      wr_reg(A_S2, 1, 16'h0000);
      smi_en = s[0]; strap = s[1]; cfg = s[2];
      do_rb = !(s[1] || s[2]);
      wr_reg(A_LIM, 1, 16'h0003);
      wr_reg(A_C1, 1, 16'h0000);
      wr_reg(A_RLD, 1, 16'h0000);
      s0 = smi_cnt; r0 = rb_cnt;
      wait_cyc(2 * P);
      rd_reg(A_S1, 1, v); check($sformatf("R3 early s=%0d", s), v, 16'h0000);
      wait_cyc(P + 2);
      rd_reg(A_S1, 1, v); check($sformatf("R3 timeout s=%0d", s), v, 16'h0008);
      check($sformatf("R3 smi s=%0d", s), 16'(smi_cnt - s0), 16'(s[0]));
      wait_cyc(3 * P);
      rd_reg(A_S2, 1, v); check($sformatf("R4 status2 s=%0d", s), v, 16'h0006);
      check($sformatf("R4 reboot s=%0d", s), 16'(rb_cnt - r0), 16'(do_rb));
      check($sformatf("R5 smi2 s=%0d", s), 16'(smi_cnt - s0),
            16'(s[0] ? (do_rb ? 1 : 2) : 0));
      rd_reg(A_RLD, 1, v1);
      wait_cyc(P);
      rd_reg(A_RLD, 1, v2);
      if (do_rb) check($sformatf("R4 stopped s=%0d", s), {v1 | v2}, 16'h0000);
      else       check($sformatf("R5 running s=%0d", s), 16'(v1 != v2), 16'h0001);
    end

    // R6: reload write clears the consecutive-expiry record
    wr_reg(A_C1, 1, HALT);
    smi_en = 1'b0; strap = 1'b0; cfg = 1'b0;
    wr_reg(A_S1, 1, 16'h0000);
    wr_reg(A_S2, 1, 16'h0000);
    wr_reg(A_C1, 1, 16'h0000);
    wr_reg(A_RLD, 1, 16'h0000);
    r0 = rb_cnt;
    wait_cyc(3 * P + 2);
    rd_reg(A_S1, 1, v); check("R6 first expiry", v, 16'h0008);
    wr_reg(A_RLD, 0, 16'h0000);
    wait_cyc(3 * P + 2);
    rd_reg(A_S2, 1, v); check("R6 no second", v, 16'h0000);
    check("R6 no reboot", 16'(rb_cnt - r0), 16'h0000);

    // R8: mailbox side effects
    wr_reg(A_C1, 1, HALT);
    wr_reg(A_S1, 1, 16'h0000);
    wait_cyc(2);
    s0 = smi_cnt;
    wr_reg(A_DIN, 0, 16'h005A);
    wait_cyc(2);
    rd_reg(A_S1, 1, v);  check("R8 din status", v, 16'h0002);
    check("R8 din smi", 16'(smi_cnt - s0), 16'h0001);
    check("R8 irq low", {15'd0, irq}, 16'h0000);
    wr_reg(A_DOUT, 0, 16'h00A5);
    rd_reg(A_S1, 1, v);  check("R8 dout status", v, 16'h0006);
    check("R8 irq high", {15'd0, irq}, 16'h0001);
    rd_reg(A_DIN, 1, v); check("R8 data bytes", v, 16'hA55A);

    // R10: masks and byte lanes
    wr_reg(A_S1, 1, 16'hFFFF);
    rd_reg(A_S1, 1, v); check("R10 status1 mask", v, 16'h000E);
    wr_reg(A_S2, 1, 16'hFFFF);
    rd_reg(A_S2, 1, v); check("R10 status2 mask", v, 16'h0006);
    wr_reg(A_MSGA, 0, 16'h77AB);
    wr_reg(A_MSGA + 5'd1, 0, 16'h88CD);
    rd_reg(A_MSGA, 1, v); check("R10 byte writes", v, 16'hCDAB);
    wr_reg(A_WDC, 1, 16'h1234);
    rd_reg(A_SWI, 0, v); check("R10 word hi lane", v, 16'h0012);
    rd_reg(A_WDC, 0, v); check("R10 word lo lane", v, 16'h0034);

    // R7: lock is sticky until reset
    wr_reg(A_C1, 1, LOCK | HALT);
    rd_reg(A_C1, 1, v); check("R7 lock set", v, 16'h1800);
    wr_reg(A_C1, 1, 16'h0000);
    rd_reg(A_C1, 1, v); check("R7 lock kept", v, 16'h1000);
    @(negedge clk) rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
    rd_reg(A_C1, 1, v); check("R7 lock cleared by reset", v, 16'h0000);
    check_reset();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule